// File: doc/BRIEF.md
# Two-Tap Adaptive Channel Mismatch Estimator

This block estimates the gain and sampling-skew mismatch between the two halves of a two-way interleaved converter. Its inputs are the calibration tone that has already been pulled out of each channel: `x0` and `x1`. An adaptive two-coefficient filter learns to predict the `x1` sample from the current and the previous `x0` sample. When the mismatch is small, the learned coefficients `h0` and `h1` hold the relative gain and the relative timing offset in a fixed linear relation.

Each update is a least-mean-squares step, with a step size set by a right-shift amount. A decimation control lets the coefficients adapt on only every Nth valid sample. Two programmable first-order maps turn the coefficient pair into a gain-error word and a timing-error word. The downstream correction engine takes these words without any further processing. An update strobe marks each cycle in which either error word has just taken a new value.

Top module: `mm_tap_estimator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `h0` equals 1.0. This is 2^CF, which is 262144 at the defaults. `h1` equals 0. During reset, `gain_err`, `timing_err` and `upd_stb` are 0.
- R2: A cycle with `in_valid` low changes neither coefficient, the held previous `x0` sample, nor the decimation count.
- R3: On an update, the prediction is p = (h0·x0 + h1·x0prev) >>> CF. The error is e = x1 − p, saturated to XW+2 signed bits. Each coefficient becomes hi + ((e·x0[n−i]) >>> mu_shift), where x0[n−0] is `x0` and x0[n−1] is x0prev. The shift is arithmetic, so it rounds toward minus infinity.
- R4: Each coefficient saturates to the signed CW-bit range, which is −524288 to 524287 at the defaults.
- R5: An internal count advances on every valid sample. An update happens on the valid sample where the count reaches N−1, and the count then restarts from 0. N is `dec_n`. A value of 0 acts as 1, and values above DEC_MAX act as DEC_MAX (16). The held previous `x0` sample is loaded on every valid sample, whether or not that sample updates the coefficients.
- R6: New coefficients appear on `h0` and `h1` at the clock edge that takes in the updating sample.
- R7: `gain_err` equals sat_OW(((a_g·h0 + b_g·h1) >>> KF) + c_g), and `timing_err` uses the same formula with `a_t`, `b_t` and `c_t`. Both are computed from the `h0`/`h1` values of the previous cycle. KF is 14 at the defaults.
- R8: `upd_stb` is high in exactly those cycles where `gain_err` or `timing_err` differs from its value in the cycle before.
- R9: `mu_shift` takes any value from 0 to 31, and the update applies exactly that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair valid |
| x0 | input | XW | Extracted tone from reference channel, signed |
| x1 | input | XW | Extracted tone from channel being matched, signed |
| mu_shift | input | MUW | LMS step size as a right shift |
| dec_n | input | DECW | Update decimation factor |
| a_g | input | KW | Gain map weight on h0, KF fraction bits |
| b_g | input | KW | Gain map weight on h1 |
| c_g | input | OW | Gain map offset |
| a_t | input | KW | Timing map weight on h0 |
| b_t | input | KW | Timing map weight on h1 |
| c_t | input | OW | Timing map offset |
| h0 | output | CW | Current-tap coefficient, CF fraction bits |
| h1 | output | CW | Previous-tap coefficient |
| gain_err | output | OW | Gain-error word |
| timing_err | output | OW | Timing-error word |
| upd_stb | output | 1 | Error words changed this cycle |

## Verification
The assertions assume three things about the inputs. Reset is held for at least one clock before use. The inputs carry known values. Any change in an error word can be traced either to a coefficient change or to a change in the mapping constants two cycles back. The stimulus sets the mapping constants once, while the block is in reset, and never changes them afterwards. Random sample pairs, step shifts and decimation factors arrive in short bursts, with `in_valid` going low at random. Directed cases drive full-scale samples with a zero shift to force both coefficients and the prediction error into saturation, and then reset the block in the middle of the run.

// File: rtl/mm_est_pkg.sv
package mm_est_pkg;
   localparam int MM_XW      = 16;
   localparam int MM_CW      = 20;
   localparam int MM_CF      = 18;
   localparam int MM_KW      = 16;
   localparam int MM_KF      = 14;
   localparam int MM_OW      = 20;
   localparam int MM_MUW     = 5;
   localparam int MM_DEC_MAX = 16;

   function automatic int bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction
endpackage

// File: rtl/mm_sat.sv
module mm_sat #(
   parameter int IW = 24,
   parameter int OW = 16
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);
   generate
      if (IW <= OW) begin : g_ext
         assign dout = OW'(din);
      end else begin : g_clip
         localparam logic signed [OW-1:0] MAXV = {1'b0, {(OW-1){1'b1}}};
         localparam logic signed [OW-1:0] MINV = {1'b1, {(OW-1){1'b0}}};
         logic [IW-OW:0] head;
         assign head = din[IW-1:OW-1];
         always_comb begin
            if ((&head) || (~|head)) dout = din[OW-1:0];
            else if (din[IW-1])      dout = MINV;
            else                     dout = MAXV;
         end
      end
   endgenerate
endmodule

// File: rtl/mm_dec_gate.sv
module mm_dec_gate #(
   parameter int DEC_MAX = 16,
   parameter int DECW    = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [DECW-1:0] dec_n,
   output logic            tick
);
   localparam int CNTW = (DEC_MAX > 1) ? $clog2(DEC_MAX) : 1;

   logic [CNTW-1:0] cnt;
   logic [CNTW-1:0] lim;

   always_comb begin
      if (dec_n == '0)                 lim = '0;
      else if (dec_n > DECW'(DEC_MAX)) lim = CNTW'(DEC_MAX - 1);
      else                             lim = CNTW'(dec_n - 1'b1);
   end

   assign tick = in_valid && (cnt >= lim);

   always_ff @(posedge clk) begin
      if (rst)           cnt <= '0;
      else if (in_valid) cnt <= (cnt >= lim) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/mm_lms_core.sv
module mm_lms_core #(
   parameter int XW  = 16,
   parameter int CW  = 20,
   parameter int CF  = 18,
   parameter int MUW = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic                 tick,
   input  logic signed [XW-1:0] x0,
   input  logic signed [XW-1:0] x1,
   input  logic [MUW-1:0]       mu,
   output logic signed [CW-1:0] h0,
   output logic signed [CW-1:0] h1
);
   localparam int EW = XW + 2;
   localparam int PW = CW + XW + 1;
   localparam int ER = PW + 1;
   localparam int GW = EW + XW;
   localparam int UW = GW + 1;
   localparam logic signed [CW-1:0] H_ONE = CW'(1) << CF;

   logic signed [XW-1:0]    x0d;
   logic signed [CW-1:0]    h_q  [2];
   logic signed [CW-1:0]    h_nx [2];
   logic signed [XW-1:0]    xs   [2];
   logic signed [CW+XW-1:0] p0, p1;
   logic signed [PW-1:0]    psum, pred;
   logic signed [ER-1:0]    e_raw;
   logic signed [EW-1:0]    e;

   assign xs[0] = x0;
   assign xs[1] = x0d;
   assign p0    = h_q[0] * x0;
   assign p1    = h_q[1] * x0d;
   assign psum  = PW'(p0) + PW'(p1);
   assign pred  = psum >>> CF;
   assign e_raw = ER'(x1) - ER'(pred);

   mm_sat #(.IW(ER), .OW(EW)) u_esat (.din(e_raw), .dout(e));

   for (genvar i = 0; i < 2; i++) begin : g_tap
      logic signed [GW-1:0] grad, step;
      logic signed [UW-1:0] acc;
      assign grad = e * xs[i];
      assign step = grad >>> mu;
      assign acc  = UW'(h_q[i]) + UW'(step);
      mm_sat #(.IW(UW), .OW(CW)) u_hsat (.din(acc), .dout(h_nx[i]));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         h_q[0] <= H_ONE;
         h_q[1] <= '0;
         x0d    <= '0;
      end else if (in_valid) begin
         x0d <= x0;
         if (tick) begin
            h_q[0] <= h_nx[0];
            h_q[1] <= h_nx[1];
         end
      end
   end

   assign h0 = h_q[0];
   assign h1 = h_q[1];
endmodule

// File: rtl/mm_lin_map.sv
module mm_lin_map #(
   parameter int CW = 20,
   parameter int KW = 16,
   parameter int KF = 14,
   parameter int OW = 20
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic signed [KW-1:0] ka,
   input  logic signed [KW-1:0] kb,
   input  logic signed [OW-1:0] kc,
   input  logic signed [CW-1:0] h0,
   input  logic signed [CW-1:0] h1,
   output logic signed [OW-1:0] q,
   output logic                 chg
);
   localparam int MW = KW + CW + 1;
   localparam int SW = (MW > OW ? MW : OW) + 1;

   logic signed [KW+CW-1:0] m0, m1;
   logic signed [MW-1:0]    msum;
   logic signed [SW-1:0]    s;
   logic signed [OW-1:0]    nx;

   assign m0   = ka * h0;
   assign m1   = kb * h1;
   assign msum = MW'(m0) + MW'(m1);
   assign s    = SW'(msum >>> KF) + SW'(kc);

   mm_sat #(.IW(SW), .OW(OW)) u_osat (.din(s), .dout(nx));

   assign chg = (nx != q);

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nx;
   end
endmodule

// File: rtl/mm_tap_estimator.sv
module mm_tap_estimator
   import mm_est_pkg::*;
#(
   parameter int XW      = MM_XW,
   parameter int CW      = MM_CW,
   parameter int CF      = MM_CF,
   parameter int KW      = MM_KW,
   parameter int KF      = MM_KF,
   parameter int OW      = MM_OW,
   parameter int MUW     = MM_MUW,
   parameter int DEC_MAX = MM_DEC_MAX,
   parameter int DECW    = bits_for(DEC_MAX)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [XW-1:0] x0,
   input  logic signed [XW-1:0] x1,
   input  logic [MUW-1:0]       mu_shift,
   input  logic [DECW-1:0]      dec_n,
   input  logic signed [KW-1:0] a_g,
   input  logic signed [KW-1:0] b_g,
   input  logic signed [OW-1:0] c_g,
   input  logic signed [KW-1:0] a_t,
   input  logic signed [KW-1:0] b_t,
   input  logic signed [OW-1:0] c_t,
   output logic signed [CW-1:0] h0,
   output logic signed [CW-1:0] h1,
   output logic signed [OW-1:0] gain_err,
   output logic signed [OW-1:0] timing_err,
   output logic                 upd_stb
);
   if (CF > CW - 2) begin : g_bad_cf
      $fatal(1, "CF must leave room for a sign bit and unity");
   end
   if (DEC_MAX < 1 || DECW < bits_for(DEC_MAX)) begin : g_bad_dec
      $fatal(1, "decimation parameters inconsistent");
   end
   if (KF >= KW + CW) begin : g_bad_kf
      $fatal(1, "KF too large for the map product");
   end

   logic tick;

   mm_dec_gate #(.DEC_MAX(DEC_MAX), .DECW(DECW)) u_dec (
      .clk(clk), .rst(rst), .in_valid(in_valid), .dec_n(dec_n), .tick(tick)
   );

   mm_lms_core #(.XW(XW), .CW(CW), .CF(CF), .MUW(MUW)) u_core (
      .clk(clk), .rst(rst), .in_valid(in_valid), .tick(tick),
      .x0(x0), .x1(x1), .mu(mu_shift), .h0(h0), .h1(h1)
   );

   logic signed [KW-1:0] ka [2];
   logic signed [KW-1:0] kb [2];
   logic signed [OW-1:0] kc [2];
   logic signed [OW-1:0] mq [2];
   logic                 mchg [2];

   assign ka[0] = a_g;  assign kb[0] = b_g;  assign kc[0] = c_g;
   assign ka[1] = a_t;  assign kb[1] = b_t;  assign kc[1] = c_t;

   for (genvar i = 0; i < 2; i++) begin : g_map
      mm_lin_map #(.CW(CW), .KW(KW), .KF(KF), .OW(OW)) u_map (
         .clk(clk), .rst(rst), .ka(ka[i]), .kb(kb[i]), .kc(kc[i]),
         .h0(h0), .h1(h1), .q(mq[i]), .chg(mchg[i])
      );
   end

   assign gain_err   = mq[0];
   assign timing_err = mq[1];

   always_ff @(posedge clk) begin
      if (rst) upd_stb <= 1'b0;
      else     upd_stb <= mchg[0] | mchg[1];
   end
endmodule

// File: rtl/mm_est_chk.sv
module mm_est_chk #(
   parameter int CW = 20,
   parameter int CF = 18,
   parameter int KW = 16,
   parameter int OW = 20
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic signed [CW-1:0] h0,
   input logic signed [CW-1:0] h1,
   input logic signed [OW-1:0] gain_err,
   input logic signed [OW-1:0] timing_err,
   input logic                 upd_stb,
   input logic signed [KW-1:0] a_g,
   input logic signed [KW-1:0] b_g,
   input logic signed [OW-1:0] c_g,
   input logic signed [KW-1:0] a_t,
   input logic signed [KW-1:0] b_t,
   input logic signed [OW-1:0] c_t
);
   localparam logic signed [CW-1:0] H_ONE = CW'(1) << CF;

   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (rst)            age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R1: coefficients start at unity / zero right after reset
   p_reset_init_r1: assert property (@(posedge clk) disable iff (rst)
      (age == 2'd0) |-> (h0 == H_ONE && h1 == '0));

   // R2: idle cycles leave the coefficients alone
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(h0) && $stable(h1)));

   // R8: strobe marks exactly the cycles with a new error word
   p_strobe_match_r8: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0) |-> (upd_stb == ((gain_err != $past(gain_err)) ||
                                     (timing_err != $past(timing_err)))));

   // R7: an error word only moves one cycle after its inputs moved
   p_map_lag_r7: assert property (@(posedge clk) disable iff (rst)
      ((age >= 2'd2) && ((gain_err != $past(gain_err)) || (timing_err != $past(timing_err))))
      |-> (($past(h0) != $past(h0, 2)) || ($past(h1) != $past(h1, 2)) ||
           ($past(a_g) != $past(a_g, 2)) || ($past(b_g) != $past(b_g, 2)) ||
           ($past(c_g) != $past(c_g, 2)) || ($past(a_t) != $past(a_t, 2)) ||
           ($past(b_t) != $past(b_t, 2)) || ($past(c_t) != $past(c_t, 2))));
endmodule

bind mm_tap_estimator mm_est_chk #(.CW(CW), .CF(CF), .KW(KW), .OW(OW)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .h0(h0), .h1(h1),
   .gain_err(gain_err), .timing_err(timing_err), .upd_stb(upd_stb),
   .a_g(a_g), .b_g(b_g), .c_g(c_g), .a_t(a_t), .b_t(b_t), .c_t(c_t)
);

// File: tb/sim_mm_tap_estimator.sv
`timescale 1ns/1ps
module sim_mm_tap_estimator;
   localparam int    XW = 16, CW = 20, CF = 18, KW = 16, KF = 14, OW = 20;
   localparam longint H_ONE = 64'sd1 <<< CF;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic signed [XW-1:0] x0 = '0, x1 = '0;
   logic [4:0] mu_shift = 5'd4;
   logic [4:0] dec_n = 5'd1;
   logic signed [KW-1:0] a_g = 16'sd16384, b_g = -16'sd3000, a_t = 16'sd500, b_t = 16'sd16384;
   logic signed [OW-1:0] c_g = -20'sd262144, c_t = 20'sd7;
   logic signed [CW-1:0] h0, h1;
   logic signed [OW-1:0] gain_err, timing_err;
   logic upd_stb;

   always #4 clk = ~clk;

   mm_tap_estimator u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .x0(x0), .x1(x1),
      .mu_shift(mu_shift), .dec_n(dec_n), .a_g(a_g), .b_g(b_g), .c_g(c_g),
      .a_t(a_t), .b_t(b_t), .c_t(c_t), .h0(h0), .h1(h1),
      .gain_err(gain_err), .timing_err(timing_err), .upd_stb(upd_stb)
   );

   int nchk = 0, nfail = 0;
   bit done = 1'b0;
   longint mh0, mh1, mx0d, mcnt, eg, et;

   function automatic longint sat(input longint v, input int w);
      longint lim = 64'sd1 <<< (w - 1);
      if (v > lim - 1) return lim - 1;
      if (v < -lim)    return -lim;
      return v;
   endfunction

   function automatic longint lmap(input longint a, input longint b, input longint c,
                                   input longint p, input longint q);
      return sat(((a * p + b * q) >>> KF) + c, OW);
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_step(input longint a, input longint b);
      longint lim, pred, e, n0, n1;
      bit t;
      lim = (dec_n == 0) ? 0 : (dec_n > 16) ? 15 : longint'(dec_n) - 1;
      t = (mcnt >= lim);
      mcnt = t ? 0 : mcnt + 1;
      if (t) begin
         pred = (mh0 * a + mh1 * mx0d) >>> CF;
         e  = sat(b - pred, XW + 2);
         n0 = sat(mh0 + ((e * a) >>> mu_shift), CW);
         n1 = sat(mh1 + ((e * mx0d) >>> mu_shift), CW);
         mh0 = n0;
         mh1 = n1;
      end
      mx0d = a;
   endtask

   task automatic step(input bit v, input longint a, input longint b, input string tag);
      longint og, ot;
      @(negedge clk);
      in_valid = v;
      x0 = XW'(a);
      x1 = XW'(b);
      @(posedge clk);
      if (v) model_step(longint'(x0), longint'(x1));
      @(negedge clk);
      in_valid = 1'b0;
      x0 = XW'($urandom);
      x1 = XW'($urandom);
      chk(tag, h0, mh0);
      chk(tag, h1, mh1);
      chk("R8 quiet", upd_stb, 0);
      og = eg; ot = et;
      eg = lmap(a_g, b_g, c_g, mh0, mh1);
      et = lmap(a_t, b_t, c_t, mh0, mh1);
      @(negedge clk);
      chk("R7 gain", gain_err, eg);
      chk("R7 timing", timing_err, et);
      chk("R8 strobe", upd_stb, (eg != og || et != ot) ? 1 : 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 h0", h0, H_ONE);
      chk("R1 h1", h1, 0);
      chk("R1 gain", gain_err, 0);
      chk("R1 timing", timing_err, 0);
      chk("R1 strobe", upd_stb, 0);
      mh0 = H_ONE; mh1 = 0; mx0d = 0; mcnt = 0;
      rst = 1'b0;
      @(negedge clk);
      chk("R1 h0 after", h0, H_ONE);
      @(negedge clk);
      eg = lmap(a_g, b_g, c_g, mh0, mh1);
      et = lmap(a_t, b_t, c_t, mh0, mh1);
      chk("R7 gain at start", gain_err, eg);
      chk("R7 timing at start", timing_err, et);
      chk("R8 settled", upd_stb, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      do_reset();

      // R3 / R6: directed updates on every sample
      dec_n = 5'd1; mu_shift = 5'd4;
      step(1, 1000, 1200, "R3");
      step(1, -2000, -1700, "R6");
      step(1, 3000, 2900, "R3");
      step(1, 0, 500, "R3");

      // R2: invalid cycles change nothing, including x0 history
      step(0, 30000, -30000, "R2");
      step(0, -12345, 777, "R2");
      step(1, 1500, 1400, "R2 history");

      // R5: decimation 3, 0 (acts as 1), 20 (acts as 16)
      dec_n = 5'd3;
      for (int i = 0; i < 9; i++) step(1, 400 * i - 1500, 350 * i - 1200, "R5 n3");
      dec_n = 5'd0;
      for (int i = 0; i < 4; i++) step(1, 900 - 300 * i, 850 - 250 * i, "R5 n0");
      dec_n = 5'd20;
      for (int i = 0; i < 34; i++) step(1, 2000 - 100 * i, 1900 - 90 * i, "R5 n16");

      // R4: full-scale samples with zero shift drive the taps to their limits
      dec_n = 5'd1; mu_shift = 5'd0;
      step(1, 100, 100, "R4 prime");
      step(1, -32768, 32767, "R4");
      chk("R4 low limit", h0, -524288);
      step(1, 32767, -32768, "R4");
      step(1, 32767, 32767, "R4");
      step(1, -32768, -32768, "R4");

      // R1: mid-run reset
      do_reset();

      // R9 / R5: random bursts with random step shifts and decimation
      for (int blk = 0; blk < 60; blk++) begin
         mu_shift = 5'($urandom_range(31, 6));
         dec_n    = 5'($urandom_range(20, 0));
         if (blk == 7) mu_shift = 5'd31;
         for (int i = 0; i < 50; i++) begin
            longint a, b;
            a = longint'($urandom_range(16000, 0)) - 8000;
            b = a + longint'($urandom_range(600, 0)) - 300;
            step(($urandom_range(9, 0) < 8) ? 1'b1 : 1'b0, a, b, "R9");
         end
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule